// File: doc/BRIEF.md
# Serial Port Interrupt Arbiter

This block decides which interrupt a 16550-style serial port presents to its host. It holds the four-bit interrupt enable register and the flag that records a pending "holding register empty" event. It also keeps the sticky break and overrun flags, which a line status read clears. From these and from level status inputs it picks the single highest-priority source. The source inputs are receive data ready, receive FIFO fill against its trigger level, character timeout, parity and framing errors, and modem status deltas. The chosen source is presented as an identification byte together with a level interrupt line.

The shift registers, FIFO storage and baud timing live elsewhere. They reach this block as status levels and as one-cycle access strobes from the register decoder. These strobes are an enable register write, an identification read, a line status read, a holding register write, a transmit FIFO reset and a holding-register-empty event. The identification byte and the interrupt line are registered. They are computed from the next-state values, so they follow any strobe or input that the same clock edge samples.

Top module: `sio_irq_arbiter`

## Requirements
- R1: The identification code in iir[3:0] is chosen in this fixed order, highest first. Line error enabled by ier bit 2 gives 0x6. Character timeout enabled by ier bit 0 gives 0xC. Receive data enabled by ier bit 0 gives 0x4. Empty-holding pending enabled by ier bit 1 gives 0x2. Modem delta enabled by ier bit 3 gives 0x0. If no source is active, the code is 0x1.
- R2: With fifo_en low, receive data requests an interrupt whenever rx_ready is high. With fifo_en high, it also needs rx_count greater than or equal to rx_trig.
- R3: The character timeout source has no enable of its own. It is masked by ier bit 0, the receive data enable.
- R4: iir[7:6] is 2'b11 while fifo_en is high and 2'b00 while it is low. iir[5:4] is always zero.
- R5: An iir_rd pulse while iir[3:0] is 0x2 clears the empty-holding pending flag. A read that returns any other code leaves the flag alone.
- R6: thr_wr clears the pending flag. txf_reset and thre_rise each set it.
- R7: When an enable write changes ier bit 1, the pending flag becomes (new bit 1 AND thre). This holds even after a read has cleared the flag. A write that leaves bit 1 unchanged does not touch the flag.
- R8: Only ier bits 3:0 are stored. ier_rdata[7:4] reads zero.
- R9: brk_set and ovr_set each set a sticky flag. An lsr_rd pulse clears both sticky flags. par_err and frm_err are levels and are not cleared by the read. lsr_err presents {break, framing, parity, overrun}, which are line status bits 4 down to 1.
- R10: irq is high exactly when iir[3:0] is not 0x1.
- R11: Reset gives iir = 0x01, irq = 0, and ier, pending and sticky flags all zero. After reset, iir and irq change on the first clock edge that samples a changed input or strobe, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | FIFO mode enabled |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| ier_rdata | output | 8 | Enable register read value |
| iir_rd | input | 1 | Identification register read strobe |
| thr_wr | input | 1 | Holding register write strobe |
| txf_reset | input | 1 | Transmit FIFO reset strobe |
| thre | input | 1 | Holding register empty status level |
| thre_rise | input | 1 | Holding register just became empty |
| lsr_rd | input | 1 | Line status read strobe |
| brk_set | input | 1 | Break detected pulse |
| ovr_set | input | 1 | Overrun detected pulse |
| par_err | input | 1 | Parity error level |
| frm_err | input | 1 | Framing error level |
| rx_ready | input | 1 | Receive data available |
| rx_count | input | CNT_W | Receive FIFO fill count |
| rx_trig | input | CNT_W | Receive FIFO trigger level |
| rx_timeout | input | 1 | Character timeout pending |
| msr_delta | input | 4 | Modem status delta bits |
| iir | output | 8 | Identification byte |
| irq | output | 1 | Level interrupt request |
| lsr_err | output | 4 | Line error bits {break, framing, parity, overrun} |

## Verification
The bench targets the trigger boundary, where a count equal to the trigger must fire. An off-by-one compare would report a modem code instead. It masks the timeout through the receive enable. A design that gave the timeout its own enable would still raise 0xC. It toggles the empty-holding enable after a clearing read and also rewrites it unchanged. A wrong re-arm rule would either lose the interrupt or raise a spurious one. It reads the identification register while a higher code is shown, to catch a design that clears the pending flag on any read. It also reads line status while a parity error level persists, to catch a design that clears more than the break and overrun flags.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;

    typedef enum logic [3:0] {
        IID_MODEM  = 4'h0,
        IID_NONE   = 4'h1,
        IID_THRE   = 4'h2,
        IID_RXDATA = 4'h4,
        IID_LINE   = 4'h6,
        IID_TMO    = 4'hC
    } iid_e;

    typedef struct packed {
        logic msi;   // bit 3
        logic lsi;   // bit 2
        logic thri;  // bit 1
        logic rdi;   // bit 0
    } ier_t;

    typedef struct packed {
        logic line;
        logic tmo;
        logic rxdata;
        logic thre;
        logic modem;
    } src_t;

    function automatic iid_e pick_source(src_t s);
        if (s.line)        return IID_LINE;
        else if (s.tmo)    return IID_TMO;
        else if (s.rxdata) return IID_RXDATA;
        else if (s.thre)   return IID_THRE;
        else if (s.modem)  return IID_MODEM;
        else               return IID_NONE;
    endfunction

endpackage

// File: rtl/sio_irq_prio.sv
module sio_irq_prio
    import sio_irq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  ier_t             en,
    input  logic             line_any,
    input  logic             rx_timeout,
    input  logic             rx_ready,
    input  logic             fifo_en,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_trig,
    input  logic             thre_pend,
    input  logic [3:0]       msr_delta,
    output iid_e             code
);
    src_t req;
    logic level_met;

    always_comb begin
        level_met  = !fifo_en || (rx_count >= rx_trig);
        req.line   = en.lsi && line_any;
        req.tmo    = en.rdi && rx_timeout;
        req.rxdata = en.rdi && rx_ready && level_met;
        req.thre   = en.thri && thre_pend;
        req.modem  = en.msi && (|msr_delta);
        code       = pick_source(req);
    end
endmodule

// File: rtl/sio_thre_pend.sv
module sio_thre_pend (
    input  logic clk,
    input  logic rst,
    input  logic ier1_chg,
    input  logic ier1_new,
    input  logic thre,
    input  logic txf_reset,
    input  logic thre_rise,
    input  logic thr_wr,
    input  logic rd_thre,
    output logic pend_d,
    output logic pend_q
);
    always_comb begin
        pend_d = pend_q;
        if (ier1_chg)       pend_d = ier1_new && thre;
        else if (txf_reset) pend_d = 1'b1;
        else if (thre_rise) pend_d = 1'b1;
        else if (thr_wr)    pend_d = 1'b0;
        else if (rd_thre)   pend_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= 1'b0;
        else     pend_q <= pend_d;
    end

    // R7
    rearm_chk: assert property (@(posedge clk) disable iff (rst)
        ier1_chg |=> (pend_q == $past(ier1_new && thre)));

    // R6
    txrst_set_chk: assert property (@(posedge clk) disable iff (rst)
        (txf_reset && !ier1_chg) |=> pend_q);

    // R6
    thrwr_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (thr_wr && !ier1_chg && !txf_reset && !thre_rise) |=> !pend_q);

    // R5
    rdclr_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_thre && !ier1_chg && !txf_reset && !thre_rise) |=> !pend_q);
endmodule

// File: rtl/sio_lsr_hold.sv
module sio_lsr_hold (
    input  logic clk,
    input  logic rst,
    input  logic brk_set,
    input  logic ovr_set,
    input  logic lsr_rd,
    output logic brk_d,
    output logic ovr_d,
    output logic brk_q,
    output logic ovr_q
);
    always_comb begin
        brk_d = brk_set || (brk_q && !lsr_rd);
        ovr_d = ovr_set || (ovr_q && !lsr_rd);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            brk_q <= 1'b0;
            ovr_q <= 1'b0;
        end else begin
            brk_q <= brk_d;
            ovr_q <= ovr_d;
        end
    end

    // R9
    brk_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (lsr_rd && !brk_set) |=> !brk_q);

    // R9
    ovr_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (lsr_rd && !ovr_set) |=> !ovr_q);
endmodule

// File: rtl/sio_irq_arbiter.sv
module sio_irq_arbiter
    import sio_irq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fifo_en,
    input  logic             ier_wr,
    input  logic [7:0]       ier_wdata,
    output logic [7:0]       ier_rdata,
    input  logic             iir_rd,
    input  logic             thr_wr,
    input  logic             txf_reset,
    input  logic             thre,
    input  logic             thre_rise,
    input  logic             lsr_rd,
    input  logic             brk_set,
    input  logic             ovr_set,
    input  logic             par_err,
    input  logic             frm_err,
    input  logic             rx_ready,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_trig,
    input  logic             rx_timeout,
    input  logic [3:0]       msr_delta,
    output logic [7:0]       iir,
    output logic             irq,
    output logic [3:0]       lsr_err
);
    localparam int IER_W = $bits(ier_t);

    ier_t       ier_q, ier_d;
    logic       ier1_chg, rd_thre;
    logic       pend_d, pend_q;
    logic       brk_d, ovr_d, brk_q, ovr_q;
    iid_e       code;
    logic [7:0] iir_d;

    always_comb begin
        ier_d    = ier_wr ? ier_t'(ier_wdata[IER_W-1:0]) : ier_q;
        ier1_chg = ier_wr && (ier_wdata[1] != ier_q.thri);
        rd_thre  = iir_rd && (iir[3:0] == IID_THRE);
    end

    sio_thre_pend u_pend (
        .clk       (clk),
        .rst       (rst),
        .ier1_chg  (ier1_chg),
        .ier1_new  (ier_wdata[1]),
        .thre      (thre),
        .txf_reset (txf_reset),
        .thre_rise (thre_rise),
        .thr_wr    (thr_wr),
        .rd_thre   (rd_thre),
        .pend_d    (pend_d),
        .pend_q    (pend_q)
    );

    sio_lsr_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .brk_set (brk_set),
        .ovr_set (ovr_set),
        .lsr_rd  (lsr_rd),
        .brk_d   (brk_d),
        .ovr_d   (ovr_d),
        .brk_q   (brk_q),
        .ovr_q   (ovr_q)
    );

    sio_irq_prio #(.CNT_W(CNT_W)) u_prio (
        .en         (ier_d),
        .line_any   (brk_d || ovr_d || par_err || frm_err),
        .rx_timeout (rx_timeout),
        .rx_ready   (rx_ready),
        .fifo_en    (fifo_en),
        .rx_count   (rx_count),
        .rx_trig    (rx_trig),
        .thre_pend  (pend_d),
        .msr_delta  (msr_delta),
        .code       (code)
    );

    always_comb iir_d = {fifo_en ? 2'b11 : 2'b00, 2'b00, 4'(code)};

    always_ff @(posedge clk) begin
        if (rst) begin
            ier_q <= '0;
            iir   <= {4'h0, 4'(IID_NONE)};
            irq   <= 1'b0;
        end else begin
            ier_q <= ier_d;
            iir   <= iir_d;
            irq   <= (code != IID_NONE);
        end
    end

    assign ier_rdata = {{(8-IER_W){1'b0}}, ier_q};
    assign lsr_err   = {brk_q, frm_err, par_err, ovr_q};

    // R4
    fifo_hdr_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_en |=> (iir[7:6] == 2'b11));

    // R10
    irq_code_chk: assert property (@(posedge clk) disable iff (rst)
        irq == (iir[3:0] != 4'h1));

    // R8
    ier_write_chk: assert property (@(posedge clk) disable iff (rst)
        ier_wr |=> (ier_rdata == {4'h0, $past(ier_wdata[3:0])}));
endmodule

// File: tb/sio_irq_arbiter_bench.sv
module sio_irq_arbiter_bench;
    localparam int CNT_W = 5;
    localparam int NV    = 12;

    // row: [31:28] ier, [27] fifo_en, [26] par, [25] frm, [24] rdy,
    //      [23] tmo, [22:19] msd, [18:14] cnt, [13:9] trig, [8] pad, [7:0] expected iir
    localparam logic [31:0] VEC [NV] = '{
        {4'b0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'b0001, 5'd0,  5'd1,  1'b0, 8'h01},
        {4'b0100, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0000, 5'd0,  5'd1,  1'b0, 8'h06},
        {4'b1101, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'b0001, 5'd8,  5'd4,  1'b0, 8'hC6},
        {4'b1001, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'b0001, 5'd8,  5'd4,  1'b0, 8'hCC},
        {4'b1001, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'b0001, 5'd8,  5'd8,  1'b0, 8'hC4},
        {4'b1001, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'b0001, 5'd7,  5'd8,  1'b0, 8'hC0},
        {4'b0001, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'b0000, 5'd0,  5'd14, 1'b0, 8'h04},
        {4'b1000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'b0100, 5'd0,  5'd1,  1'b0, 8'h00},
        {4'b0100, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'b0000, 5'd0,  5'd1,  1'b0, 8'hC6},
        {4'b1000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000, 5'd0,  5'd1,  1'b0, 8'hC1},
        {4'b1100, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'b0000, 5'd0,  5'd1,  1'b0, 8'h01},
        {4'b0001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'b0000, 5'd0,  5'd1,  1'b0, 8'hCC}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fifo_en = 0, ier_wr = 0, iir_rd = 0, thr_wr = 0, txf_reset = 0;
    logic thre = 0, thre_rise = 0, lsr_rd = 0, brk_set = 0, ovr_set = 0;
    logic par_err = 0, frm_err = 0, rx_ready = 0, rx_timeout = 0;
    logic [7:0] ier_wdata = 0;
    logic [CNT_W-1:0] rx_count = 0, rx_trig = 0;
    logic [3:0] msr_delta = 0;
    logic [7:0] ier_rdata, iir;
    logic irq;
    logic [3:0] lsr_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    sio_irq_arbiter #(.CNT_W(CNT_W)) u_sio_irq_arbiter (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .ier_wr(ier_wr),
        .ier_wdata(ier_wdata), .ier_rdata(ier_rdata), .iir_rd(iir_rd),
        .thr_wr(thr_wr), .txf_reset(txf_reset), .thre(thre),
        .thre_rise(thre_rise), .lsr_rd(lsr_rd), .brk_set(brk_set),
        .ovr_set(ovr_set), .par_err(par_err), .frm_err(frm_err),
        .rx_ready(rx_ready), .rx_count(rx_count), .rx_trig(rx_trig),
        .rx_timeout(rx_timeout), .msr_delta(msr_delta), .iir(iir),
        .irq(irq), .lsr_err(lsr_err)
    );

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_iir(string tag, logic [7:0] exp);
        check(tag, iir, exp);
        check({tag, " irq R10"}, {7'd0, irq}, {7'd0, exp[3:0] != 4'h1});
    endtask

    task automatic write_ier(logic [7:0] v);
        @(negedge clk);
        ier_wr = 1; ier_wdata = v;
        @(negedge clk);
        ier_wr = 0;
    endtask

    task automatic pulse_iir_rd();
        @(negedge clk); iir_rd = 1; @(negedge clk); iir_rd = 0;
    endtask
    task automatic pulse_thr_wr();
        @(negedge clk); thr_wr = 1; @(negedge clk); thr_wr = 0;
    endtask
    task automatic pulse_txf();
        @(negedge clk); txf_reset = 1; @(negedge clk); txf_reset = 0;
    endtask
    task automatic pulse_rise();
        @(negedge clk); thre_rise = 1; @(negedge clk); thre_rise = 0;
    endtask
    task automatic pulse_lsr_rd();
        @(negedge clk); lsr_rd = 1; @(negedge clk); lsr_rd = 0;
    endtask
    task automatic pulse_brk();
        @(negedge clk); brk_set = 1; @(negedge clk); brk_set = 0;
    endtask
    task automatic pulse_ovr();
        @(negedge clk); ovr_set = 1; @(negedge clk); ovr_set = 0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            summary();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R11 reset state
        check_iir("R11 reset iir", 8'h01);
        check("R11 reset ier", ier_rdata, 8'h00);

        // table: R1 R2 R3 R4
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            fifo_en   = VEC[i][27];
            par_err   = VEC[i][26];
            frm_err   = VEC[i][25];
            rx_ready  = VEC[i][24];
            rx_timeout= VEC[i][23];
            msr_delta = VEC[i][22:19];
            rx_count  = VEC[i][18:14];
            rx_trig   = VEC[i][13:9];
            ier_wr    = 1;
            ier_wdata = {4'h0, VEC[i][31:28]};
            @(negedge clk);
            ier_wr = 0;
            check_iir($sformatf("R1/R2/R3/R4 row %0d", i), VEC[i][7:0]);
        end

        @(negedge clk);
        fifo_en = 0; par_err = 0; frm_err = 0; rx_ready = 0;
        rx_timeout = 0; msr_delta = 0; rx_count = 0; rx_trig = 0;
        thre = 1;
        // R8 upper bits dropped; R7 bit1 rising with thre high arms pending
        write_ier(8'hFF);
        check("R8 ier readback", ier_rdata, 8'h0F);
        check_iir("R7 arm on enable", 8'h02);
        // R5 read returning 0x2 clears
        pulse_iir_rd();
        check_iir("R5 read clears", 8'h01);
        // R7 unchanged bit1 does not re-arm
        write_ier(8'h0F);
        check_iir("R7 no change", 8'h01);
        write_ier(8'h0D);
        check_iir("R7 disable", 8'h01);
        write_ier(8'h0F);
        check_iir("R7 re-arm after read", 8'h02);
        @(negedge clk); thre = 0;
        write_ier(8'h0D);
        write_ier(8'h0F);
        check_iir("R7 thre low no arm", 8'h01);
        // R6
        pulse_txf();
        check_iir("R6 txf reset sets", 8'h02);
        pulse_thr_wr();
        check_iir("R6 thr write clears", 8'h01);
        pulse_rise();
        check_iir("R6 empty event sets", 8'h02);
        // R5 read of higher code keeps pending
        @(negedge clk); rx_ready = 1;
        @(negedge clk);
        check_iir("R1 rx over thre", 8'h04);
        pulse_iir_rd();
        check_iir("R5 other read", 8'h04);
        @(negedge clk); rx_ready = 0;
        @(negedge clk);
        check_iir("R5 pending kept", 8'h02);
        pulse_thr_wr();
        check_iir("R6 clear again", 8'h01);
        // R9 sticky flags
        pulse_brk();
        check_iir("R9 break", 8'h06);
        check("R9 break flag", {4'h0, lsr_err}, 8'h08);
        pulse_lsr_rd();
        check_iir("R9 break cleared", 8'h01);
        check("R9 flags clear", {4'h0, lsr_err}, 8'h00);
        pulse_ovr();
        check("R9 overrun flag", {4'h0, lsr_err}, 8'h01);
        @(negedge clk); par_err = 1;
        pulse_lsr_rd();
        check("R9 parity stays", {4'h0, lsr_err}, 8'h02);
        check_iir("R9 parity line err", 8'h06);
        @(negedge clk); par_err = 0;
        @(negedge clk);
        check_iir("R9 parity gone", 8'h01);
        // R11 latency: unchanged before the edge, updated after
        @(negedge clk); rx_ready = 1;
        #1;
        check_iir("R11 before edge", 8'h01);
        @(negedge clk);
        check_iir("R11 after edge", 8'h04);
        // R11 reset mid-run
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0; rx_ready = 0;
        check_iir("R11 re-reset iir", 8'h01);
        check("R11 re-reset ier", ier_rdata, 8'h00);

        done = 1;
        summary();
    end
endmodule